// File: doc/BRIEF.md
# Machine-Mode CSR File with Trap Redirect

This block keeps four machine-mode control and status registers for a small processor core. These are a status word, a trap vector base, an exception return address and a cause code. It also decides where instruction fetch goes next. The core presents a CSR access (a 12-bit CSR number, an operation code and an operand) and gets back the addressed register's value in the same cycle. That value is what the core writes back for CSR instructions and for the return-from-trap instruction.

When the core raises a trap pulse with a cause code, the block steers the next PC to the trap vector. On the same clock edge it records the faulting PC and the cause. When the core signals a trap return, the next PC becomes the saved exception address. Otherwise the core's own sequential or branch target passes through unchanged. An asynchronous active-low reset clears every register, and the block releases that reset synchronously inside itself.

Top module: `mcsr_trap_unit`

## Requirements
- R1: Within two clock edges of reset release, all four CSRs read zero, and with no trap and no return `next_pc_o` equals `seq_pc_i`.
- R2: The register map is: status at 0x300, trap vector at 0x305, exception PC at 0x341, cause at 0x342. `csr_rdata_o` shows the addressed register's value before any write in that cycle.
- R3: With `csr_req_i` high and op 3'b001, the addressed CSR takes `csr_wdata_i` at the next clock edge.
- R4: Op 3'b010 ORs `csr_wdata_i` into the addressed CSR, and op 3'b011 clears the bits set in `csr_wdata_i`.
- R5: Any other op value, or `csr_req_i` low, leaves every CSR unchanged.
- R6: An address outside the map reads zero, and a write to it changes none of the four CSRs.
- R7: Bits [1:0] of the trap vector and of the exception PC always read zero.
- R8: While `trap_i` is high, `next_pc_o` equals the trap vector. At the next edge the exception PC takes `cur_pc_i` with bits [1:0] cleared, and the cause takes `trap_cause_i`.
- R9: With `mret_i` high and `trap_i` low, `next_pc_o` equals the exception PC.
- R10: A trap wins over a CSR write in the same cycle (the write is dropped) and over a simultaneous return.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csr_req_i | input | 1 | CSR access this cycle |
| csr_op_i | input | 3 | Operation: 001 write, 010 set bits, 011 clear bits |
| csr_addr_i | input | 12 | CSR number |
| csr_wdata_i | input | 32 | Operand for the access |
| trap_i | input | 1 | Exception taken this cycle |
| trap_cause_i | input | 32 | Cause code recorded on a trap |
| mret_i | input | 1 | Return from trap this cycle |
| cur_pc_i | input | 32 | PC of the current instruction |
| seq_pc_i | input | 32 | Next PC when no redirect applies |
| csr_rdata_o | output | 32 | Value of the addressed CSR |
| next_pc_o | output | 32 | Selected next PC |

## Verification
The properties assume that every input is driven to a known value whenever the internal reset is inactive. They also assume that the trap, return and request inputs last exactly one cycle per event, so that a check one edge later refers to that event alone. The stimulus changes inputs only on falling edges. Each operation is held for one full cycle, and each trap is followed by read-only cycles with `csr_req_i` low, so that the recorded exception PC and cause are observed before anything disturbs them.

// File: rtl/mcsr_pkg.sv
package mcsr_pkg;
  localparam int unsigned CSR_AW = 12;

  localparam logic [CSR_AW-1:0] ADDR_STATUS = 12'h300;
  localparam logic [CSR_AW-1:0] ADDR_TVEC   = 12'h305;
  localparam logic [CSR_AW-1:0] ADDR_EPC    = 12'h341;
  localparam logic [CSR_AW-1:0] ADDR_CAUSE  = 12'h342;

  typedef enum logic [2:0] {
    OP_WRITE = 3'b001,
    OP_SET   = 3'b010,
    OP_CLEAR = 3'b011
  } csr_op_e;
endpackage

// File: rtl/mcsr_rst_sync.sv
module mcsr_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/mcsr_update.sv
module mcsr_update
  import mcsr_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic [2:0]      op,
  input  logic [XLEN-1:0] old_val,
  input  logic [XLEN-1:0] operand,
  output logic [XLEN-1:0] new_val,
  output logic            op_ok
);
  always_comb begin
    new_val = old_val;
    op_ok   = 1'b1;
    case (op)
      OP_WRITE: new_val = operand;
      OP_SET:   new_val = old_val | operand;
      OP_CLEAR: new_val = old_val & ~operand;
      default:  op_ok   = 1'b0;
    endcase
  end
endmodule

// File: rtl/mcsr_regs.sv
module mcsr_regs
  import mcsr_pkg::*;
#(
  parameter int unsigned XLEN      = 32,
  parameter int unsigned ALIGN_LSB = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CSR_AW-1:0] addr,
  input  logic              wr_en,
  input  logic [XLEN-1:0]   wr_val,
  input  logic              trap,
  input  logic [XLEN-1:0]   trap_pc,
  input  logic [XLEN-1:0]   trap_cause,
  output logic [XLEN-1:0]   rd_val,
  output logic [XLEN-1:0]   status_q,
  output logic [XLEN-1:0]   tvec_q,
  output logic [XLEN-1:0]   epc_q,
  output logic [XLEN-1:0]   cause_q
);
  localparam logic [XLEN-1:0] ALIGN_MASK = {{(XLEN-ALIGN_LSB){1'b1}}, {ALIGN_LSB{1'b0}}};

  logic            sel_status, sel_tvec, sel_epc, sel_cause;
  logic            en_status, en_tvec, en_epc, en_cause;
  logic [XLEN-1:0] status_d, tvec_d, epc_d, cause_d;

  always_comb begin
    sel_status = (addr == ADDR_STATUS);
    sel_tvec   = (addr == ADDR_TVEC);
    sel_epc    = (addr == ADDR_EPC);
    sel_cause  = (addr == ADDR_CAUSE);

    en_status = wr_en && sel_status;
    en_tvec   = wr_en && sel_tvec;
    en_epc    = trap || (wr_en && sel_epc);
    en_cause  = trap || (wr_en && sel_cause);

    status_d = wr_val;
    tvec_d   = wr_val & ALIGN_MASK;
    epc_d    = (trap ? trap_pc : wr_val) & ALIGN_MASK;
    cause_d  = trap ? trap_cause : wr_val;

    rd_val = '0;
    if (sel_status) rd_val = status_q;
    if (sel_tvec)   rd_val = tvec_q;
    if (sel_epc)    rd_val = epc_q;
    if (sel_cause)  rd_val = cause_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
      tvec_q   <= '0;
      epc_q    <= '0;
      cause_q  <= '0;
    end else begin
      if (en_status) status_q <= status_d;
      if (en_tvec)   tvec_q   <= tvec_d;
      if (en_epc)    epc_q    <= epc_d;
      if (en_cause)  cause_q  <= cause_d;
    end
  end
endmodule

// File: rtl/mcsr_npc_sel.sv
module mcsr_npc_sel #(
  parameter int unsigned XLEN = 32
) (
  input  logic            trap,
  input  logic            mret,
  input  logic [XLEN-1:0] tvec,
  input  logic [XLEN-1:0] epc,
  input  logic [XLEN-1:0] seq_pc,
  output logic [XLEN-1:0] next_pc
);
  always_comb begin
    if (trap)      next_pc = tvec;
    else if (mret) next_pc = epc;
    else           next_pc = seq_pc;
  end
endmodule

// File: rtl/mcsr_trap_unit.sv
module mcsr_trap_unit
  import mcsr_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              csr_req_i,
  input  logic [2:0]        csr_op_i,
  input  logic [CSR_AW-1:0] csr_addr_i,
  input  logic [XLEN-1:0]   csr_wdata_i,
  input  logic              trap_i,
  input  logic [XLEN-1:0]   trap_cause_i,
  input  logic              mret_i,
  input  logic [XLEN-1:0]   cur_pc_i,
  input  logic [XLEN-1:0]   seq_pc_i,
  output logic [XLEN-1:0]   csr_rdata_o,
  output logic [XLEN-1:0]   next_pc_o
);
  logic            rst_n_sync;
  logic [XLEN-1:0] upd_val;
  logic            upd_ok;
  logic            wr_en;
  logic [XLEN-1:0] status_q, tvec_q, epc_q, cause_q;

  mcsr_rst_sync #(.STAGES(2)) rst_sync_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  mcsr_update #(.XLEN(XLEN)) update_i (
    .op      (csr_op_i),
    .old_val (csr_rdata_o),
    .operand (csr_wdata_i),
    .new_val (upd_val),
    .op_ok   (upd_ok)
  );

  // A trap in the same cycle suppresses the software write.
  assign wr_en = csr_req_i && upd_ok && !trap_i;

  mcsr_regs #(.XLEN(XLEN), .ALIGN_LSB(2)) regs_i (
    .clk        (clk),
    .rst_n      (rst_n_sync),
    .addr       (csr_addr_i),
    .wr_en      (wr_en),
    .wr_val     (upd_val),
    .trap       (trap_i),
    .trap_pc    (cur_pc_i),
    .trap_cause (trap_cause_i),
    .rd_val     (csr_rdata_o),
    .status_q   (status_q),
    .tvec_q     (tvec_q),
    .epc_q      (epc_q),
    .cause_q    (cause_q)
  );

  mcsr_npc_sel #(.XLEN(XLEN)) npc_sel_i (
    .trap    (trap_i),
    .mret    (mret_i),
    .tvec    (tvec_q),
    .epc     (epc_q),
    .seq_pc  (seq_pc_i),
    .next_pc (next_pc_o)
  );
endmodule

// File: rtl/mcsr_trap_unit_chk.sv
module mcsr_trap_unit_chk
  import mcsr_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              csr_req_i,
  input logic [2:0]        csr_op_i,
  input logic [CSR_AW-1:0] csr_addr_i,
  input logic              trap_i,
  input logic [XLEN-1:0]   trap_cause_i,
  input logic              mret_i,
  input logic [XLEN-1:0]   cur_pc_i,
  input logic [XLEN-1:0]   csr_rdata_o,
  input logic [XLEN-1:0]   next_pc_o,
  input logic [XLEN-1:0]   status_q,
  input logic [XLEN-1:0]   tvec_q,
  input logic [XLEN-1:0]   epc_q,
  input logic [XLEN-1:0]   cause_q
);
  logic addr_known;
  assign addr_known = (csr_addr_i == ADDR_STATUS) || (csr_addr_i == ADDR_TVEC) ||
                      (csr_addr_i == ADDR_EPC)    || (csr_addr_i == ADDR_CAUSE);

  AST_TRAP_EPC: assert property (@(posedge clk) disable iff (!rst_n)
    trap_i |=> epc_q == ($past(cur_pc_i) & ~32'h3)); // R8
  AST_TRAP_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    trap_i |=> cause_q == $past(trap_cause_i)); // R8
  AST_TRAP_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    trap_i |-> next_pc_o == tvec_q); // R8
  AST_RETURN_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    (mret_i && !trap_i) |-> next_pc_o == epc_q); // R9
  AST_LOW_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ((csr_addr_i == ADDR_TVEC) || (csr_addr_i == ADDR_EPC)) |-> csr_rdata_o[1:0] == 2'b00); // R7
  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !addr_known |-> csr_rdata_o == '0); // R6
  AST_TRAP_BLOCKS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_i && csr_req_i && csr_addr_i == ADDR_STATUS) |=> $stable(status_q)); // R10
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!csr_req_i && !trap_i) |=> ($stable(status_q) && $stable(tvec_q) &&
                                 $stable(epc_q) && $stable(cause_q))); // R5
  AST_BAD_OP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!trap_i && !(csr_op_i inside {3'b001, 3'b010, 3'b011})) |=>
      ($stable(status_q) && $stable(tvec_q) && $stable(epc_q) && $stable(cause_q))); // R5
endmodule

bind mcsr_trap_unit mcsr_trap_unit_chk #(.XLEN(XLEN)) chk_i (
  .clk          (clk),
  .rst_n        (rst_n_sync),
  .csr_req_i    (csr_req_i),
  .csr_op_i     (csr_op_i),
  .csr_addr_i   (csr_addr_i),
  .trap_i       (trap_i),
  .trap_cause_i (trap_cause_i),
  .mret_i       (mret_i),
  .cur_pc_i     (cur_pc_i),
  .csr_rdata_o  (csr_rdata_o),
  .next_pc_o    (next_pc_o),
  .status_q     (status_q),
  .tvec_q       (tvec_q),
  .epc_q        (epc_q),
  .cause_q      (cause_q)
);

// File: tb/mcsr_trap_unit_tb_top.sv
module mcsr_trap_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        csr_req;
  logic [2:0]  csr_op;
  logic [11:0] csr_addr;
  logic [31:0] csr_wdata;
  logic        trap;
  logic [31:0] trap_cause;
  logic        mret;
  logic [31:0] cur_pc;
  logic [31:0] seq_pc;
  logic [31:0] csr_rdata;
  logic [31:0] next_pc;

  always #2 clk = ~clk; // 250 MHz

  mcsr_trap_unit dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .csr_req_i    (csr_req),
    .csr_op_i     (csr_op),
    .csr_addr_i   (csr_addr),
    .csr_wdata_i  (csr_wdata),
    .trap_i       (trap),
    .trap_cause_i (trap_cause),
    .mret_i       (mret),
    .cur_pc_i     (cur_pc),
    .seq_pc_i     (seq_pc),
    .csr_rdata_o  (csr_rdata),
    .next_pc_o    (next_pc)
  );

  typedef struct {
    string       tag;
    logic [31:0] rd;
    logic [31:0] npc;
  } item_t;

  item_t sb_q[$];
  int    n_cmp  = 0;
  int    n_fail = 0;
  bit    done   = 1'b0;

  // Reference state built from the requirements.
  logic [31:0] m_st = '0, m_tv = '0, m_ep = '0, m_ca = '0;

  function automatic logic [31:0] m_read(input logic [11:0] a);
    case (a)
      12'h300: return m_st;
      12'h305: return m_tv;
      12'h341: return m_ep;
      12'h342: return m_ca;
      default: return 32'h0;
    endcase
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
      $finish;
    end
  endtask

  task automatic step(input bit req, input logic [2:0] op, input logic [11:0] a,
                      input logic [31:0] wd, input bit tr, input logic [31:0] cs,
                      input bit mr, input logic [31:0] pc, input logic [31:0] sq,
                      input string tag);
    item_t       it;
    logic [31:0] old, nv;
    bit          ok;
    @(negedge clk);
    csr_req = req; csr_op = op; csr_addr = a; csr_wdata = wd;
    trap = tr; trap_cause = cs; mret = mr; cur_pc = pc; seq_pc = sq;
    old    = m_read(a);
    it.tag = tag;
    it.rd  = old;
    it.npc = tr ? m_tv : (mr ? m_ep : sq);
    sb_q.push_back(it);
    ok = 1'b1;
    case (op)
      3'b001:  nv = wd;
      3'b010:  nv = old | wd;
      3'b011:  nv = old & ~wd;
      default: begin nv = old; ok = 1'b0; end
    endcase
    if (tr) begin
      m_ep = pc & ~32'h3;
      m_ca = cs;
    end else if (req && ok) begin
      case (a)
        12'h300: m_st = nv;
        12'h305: m_tv = nv & ~32'h3;
        12'h341: m_ep = nv & ~32'h3;
        12'h342: m_ca = nv;
        default: ;
      endcase
    end
  endtask

  task automatic rd(input logic [11:0] a, input string tag);
    step(1'b0, 3'b000, a, 32'h0, 1'b0, 32'h0, 1'b0, 32'h0, 32'h0000_0080, tag);
  endtask

  task automatic wr(input logic [2:0] op, input logic [11:0] a, input logic [31:0] wd,
                    input string tag);
    step(1'b1, op, a, wd, 1'b0, 32'h0, 1'b0, 32'h0, 32'h0000_0040, tag);
  endtask

  // Monitor: pops the expected item after the driver has applied it.
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (sb_q.size() > 0) begin
        item_t it;
        it = sb_q.pop_front();
        n_cmp++;
        if (csr_rdata !== it.rd) begin
          n_fail++;
          $display("FAIL %s rdata actual %h expected %h", it.tag, csr_rdata, it.rd);
        end
        n_cmp++;
        if (next_pc !== it.npc) begin
          n_fail++;
          $display("FAIL %s next_pc actual %h expected %h", it.tag, next_pc, it.npc);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual running expected finished");
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0; csr_req = 1'b0; csr_op = 3'b000; csr_addr = '0; csr_wdata = '0;
    trap = 1'b0; trap_cause = '0; mret = 1'b0; cur_pc = '0; seq_pc = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: reset values and pass-through PC
    rd(12'h300, "R1 status");
    rd(12'h305, "R1 tvec");
    rd(12'h341, "R1 epc");
    rd(12'h342, "R1 cause");

    // R3 and R2: a write returns the old value and lands at the edge
    wr(3'b001, 12'h300, 32'hA5A5_0F0F, "R3 R2 write status");
    rd(12'h300, "R3 status readback");
    wr(3'b001, 12'h342, 32'h8000_0007, "R3 write cause");
    rd(12'h342, "R3 cause readback");
    // R7: alignment bits forced to zero
    wr(3'b001, 12'h305, 32'h0000_1003, "R7 write tvec");
    rd(12'h305, "R7 tvec readback");
    wr(3'b001, 12'h341, 32'h2222_2227, "R7 write epc");
    rd(12'h341, "R7 epc readback");

    // R4: set and clear bits
    wr(3'b010, 12'h300, 32'h0000_F000, "R4 set status");
    rd(12'h300, "R4 status after set");
    wr(3'b011, 12'h300, 32'h0000_000F, "R4 clear status");
    rd(12'h300, "R4 status after clear");
    wr(3'b010, 12'h305, 32'h0000_0003, "R4 R7 set low tvec bits");
    rd(12'h305, "R4 R7 tvec after set");

    // R5: inactive op codes and no request
    wr(3'b000, 12'h300, 32'hFFFF_FFFF, "R5 op 000");
    wr(3'b101, 12'h300, 32'hFFFF_FFFF, "R5 op 101");
    wr(3'b111, 12'h342, 32'h0, "R5 op 111");
    step(1'b0, 3'b001, 12'h300, 32'h0, 1'b0, 32'h0, 1'b0, 32'h0, 32'h44, "R5 no request");
    rd(12'h300, "R5 status unchanged");
    rd(12'h342, "R5 cause unchanged");

    // R6: unmapped address
    wr(3'b001, 12'h340, 32'hDEAD_BEEF, "R6 write unmapped");
    rd(12'h340, "R6 unmapped reads zero");
    rd(12'h300, "R6 status intact");
    rd(12'h305, "R6 tvec intact");
    rd(12'h341, "R6 epc intact");
    rd(12'h342, "R6 cause intact");

    // R8: trap entry
    step(1'b0, 3'b000, 12'h300, 32'h0, 1'b1, 32'h0000_0002, 1'b0,
         32'h0000_0106, 32'h0000_010A, "R8 trap redirect");
    rd(12'h341, "R8 epc saved");
    rd(12'h342, "R8 cause saved");

    // R9: return and plain pass-through
    step(1'b0, 3'b000, 12'h341, 32'h0, 1'b0, 32'h0, 1'b1, 32'h0, 32'h0000_0200,
         "R9 return to epc");
    step(1'b0, 3'b000, 12'h300, 32'h0, 1'b0, 32'h0, 1'b0, 32'h0, 32'h0000_0208,
         "R9 sequential pc");

    // R10: trap beats a write and a return
    step(1'b1, 3'b001, 12'h300, 32'h1234_5678, 1'b1, 32'h0000_000B, 1'b0,
         32'h0000_0300, 32'h0000_0304, "R10 trap with status write");
    rd(12'h300, "R10 status not written");
    step(1'b1, 3'b001, 12'h341, 32'h0000_0FF0, 1'b1, 32'h0000_0005, 1'b1,
         32'h0000_0411, 32'h0000_0414, "R10 trap with return and epc write");
    rd(12'h341, "R10 epc from trap");
    rd(12'h342, "R10 cause from trap");

    @(negedge clk);
    @(negedge clk);
    finish_run();
  end
endmodule